// File: doc/BRIEF.md
# Polyphase Resampler Subfilter Scheduler

This block sequences a polyphase filter bank used for rational resampling. Complex samples arrive on a valid/ready input stream. Each sample is a 32-bit word with the real part in bits 31:16 and the imaginary part in bits 15:0. Accepted samples go into a 16-word circular sample bank. The scheduler picks the subfilter (phase) to evaluate next and decides how many fresh samples that phase needs. It then emits one beat per tap on a valid/ready output stream. Each beat carries the sample-bank read address, the sample read from the bank, the coefficient-bank address, the subfilter index, and start/last markers that frame one output for the downstream accumulator.

Two ways of producing the phase sequence exist. Counter mode keeps a live phase accumulator that steps by a fixed stride modulo the subfilter count. Table mode replays a per-step index table that is computed at elaboration. Table mode also raises a select on outputs whose data load is reused by the next output. The mode is captured while reset is held.

Back-pressure rules: an input sample transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid`. An output beat transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output field holds its value and `out_valid` stays high. The block never accepts input while it has a beat to offer.

Top module: `polyphase_sched`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. The first accepted sample is stored at bank word 0, and each later sample goes to the next word modulo 16.
- R2: `in_ready` is high exactly while the scheduler still needs samples for the next output. `in_ready` and `out_valid` are never high in the same cycle.
- R3: No output is offered until 2 samples (the tap count) have been loaded after reset. After an output with phase p completes, the next output waits for floor((p+S)/5) new samples, where S is the active stride. A count of 0 means the next output starts at once on the same data load.
- R4: In counter mode (`use_table`=0 during reset) the subfilter order starts at 4 and steps by +3 modulo 5, giving the repeating sequence 4,2,0,3,1.
- R5: In table mode (`use_table`=1 during reset) the order comes from the stored table for stride 2 starting at 4, giving the repeating sequence 4,1,3,0,2.
- R6: Each output is 2 beats, tap 0 then tap 1. Tap t reads bank address (newest sample address − t) modulo 16, and `out_data` is the sample stored there.
- R7: The coefficient address of tap t of subfilter s is t·5 + s, which lies in 0..9.
- R8: `out_start` is 1 on tap 0 only and `out_last` is 1 on the final tap only. Every accepted last beat is followed by a start beat.
- R9: In table mode `out_tgt` is 1 on an output exactly when that output's phase needs 0 new samples before the next output. In counter mode `out_tgt` is always 0.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and every output field stays unchanged.
- R11: Changes on `use_table` after reset is released have no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; `use_table` is captured while it is low |
| use_table | input | 1 | 1 selects table-driven indices, 0 selects counter indices |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Scheduler can take a sample |
| in_data | input | 32 | Sample: real in 31:16, imaginary in 15:0 |
| out_valid | output | 1 | Tap beat valid |
| out_ready | input | 1 | Downstream MAC takes the beat |
| out_sub | output | 3 | Subfilter index 0..4 |
| out_coef | output | 4 | Coefficient-bank address 0..9 |
| out_addr | output | 4 | Sample-bank read address |
| out_data | output | 32 | Sample read from the bank |
| out_start | output | 1 | First tap of an output |
| out_last | output | 1 | Last tap of an output |
| out_tgt | output | 1 | Table mode: this output's data load is reused by the next one |

## Verification
The bench targets the zero-advance steps, where the same data load serves two phases back to back. A scheduler that always waits for a sample there would stall, and the mismatch would show in the flow checks. The bench also covers the wrap of the 16-word bank and of the phase sequence: a wrong modulo would read stale samples or visit a subfilter out of order, and the address, data and order checks would report it. Heavy back-pressure is mixed with full-rate streaming. Any field that moved while a beat was stalled, or a beat that dropped out, would fail the hold checks. Runs also toggle the mode pin after reset; a design that followed the live pin would switch sequences mid-run.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  // phase used by step i of a stride walk that begins at start
  function automatic int phase_at(input int start, input int stride,
                                  input int nsub, input int i);
    return (start + i * stride) % nsub;
  endfunction

  // samples that must arrive after phase ph before the following phase runs
  function automatic int advance_of(input int ph, input int stride,
                                    input int nsub);
    return (ph + stride) / nsub;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rsp_sample_bank.sv
module rsp_sample_bank #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rsp_phase_counter.sv
module rsp_phase_counter #(
  parameter int NSUB   = 5,
  parameter int STRIDE = 3,
  parameter int START  = 4,
  parameter int SUB_W  = 3,
  parameter int ADV_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SUB_W-1:0] sub,
  output logic [ADV_W-1:0] adv
);

  localparam int SUM_W = $clog2(NSUB + STRIDE + 1);

  logic [SUB_W-1:0] sub_q;
  logic [SUM_W-1:0] sum;
  logic [SUB_W-1:0] nxt;

  always_comb begin
    sum = SUM_W'(sub_q) + SUM_W'(STRIDE);
    adv = ADV_W'(sum / SUM_W'(NSUB));
    nxt = SUB_W'(sum % SUM_W'(NSUB));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sub_q <= SUB_W'(START);
    else if (step) sub_q <= nxt;
  end

  assign sub = sub_q;

  AST_CNT_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sub_q) < NSUB); // R4

endmodule

// File: rtl/rsp_phase_table.sv
module rsp_phase_table #(
  parameter int NSUB   = 5,
  parameter int STRIDE = 2,
  parameter int START  = 4,
  parameter int SUB_W  = 3,
  parameter int ADV_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [SUB_W-1:0] sub,
  output logic [ADV_W-1:0] adv,
  output logic             reuse
);

  localparam int IDX_W = $clog2(NSUB);

  logic [SUB_W-1:0] tbl_sub [NSUB];
  logic [ADV_W-1:0] tbl_adv [NSUB];
  logic [IDX_W-1:0] idx_q;

  for (genvar i = 0; i < NSUB; i++) begin : g_ent
    localparam int PH = rsp_pkg::phase_at(START, STRIDE, NSUB, i);
    localparam int AD = rsp_pkg::advance_of(PH, STRIDE, NSUB);
    assign tbl_sub[i] = SUB_W'(PH);
    assign tbl_adv[i] = ADV_W'(AD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= '0;
    else if (step)
      idx_q <= (int'(idx_q) == NSUB - 1) ? '0 : idx_q + 1'b1;
  end

  assign sub   = tbl_sub[idx_q];
  assign adv   = tbl_adv[idx_q];
  assign reuse = (adv == '0);

  AST_TBL_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx_q) < NSUB); // R5

endmodule

// File: rtl/polyphase_sched.sv
module polyphase_sched #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int NSUB       = 5,
  parameter int TAPS       = 2,
  parameter int CNT_STRIDE = 3,
  parameter int TBL_STRIDE = 2,
  localparam int AW      = $clog2(DEPTH),
  localparam int SUB_W   = $clog2(NSUB),
  localparam int CW      = $clog2(NSUB * TAPS),
  localparam int TAP_W   = $clog2(TAPS),
  localparam int ADV_MAX = rsp_pkg::max2((NSUB - 1 + CNT_STRIDE) / NSUB,
                                         (NSUB - 1 + TBL_STRIDE) / NSUB),
  localparam int ADV_W   = $clog2(ADV_MAX + 1),
  localparam int NEED_W  = $clog2(rsp_pkg::max2(TAPS, ADV_MAX) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_table,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SUB_W-1:0]  out_sub,
  output logic [CW-1:0]     out_coef,
  output logic [AW-1:0]     out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_last,
  output logic              out_tgt
);

  localparam int START = NSUB - 1;

  logic              mode_q;
  logic [AW-1:0]     newest_q;
  logic [NEED_W-1:0] need_q;
  logic [TAP_W-1:0]  tap_q;
  logic              take, fire, step;
  logic [AW-1:0]     wr_addr;

  logic [SUB_W-1:0]  c_sub, t_sub, sub;
  logic [ADV_W-1:0]  c_adv, t_adv, adv;
  logic              t_reuse;

  assign in_ready  = (need_q != '0);
  assign out_valid = (need_q == '0);
  assign take      = in_valid & in_ready;
  assign fire      = out_valid & out_ready;
  assign step      = fire & (int'(tap_q) == TAPS - 1);
  assign wr_addr   = newest_q + 1'b1;

  // capture the index mode only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= use_table;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      newest_q <= AW'(DEPTH - 1);
      need_q   <= NEED_W'(TAPS);
      tap_q    <= '0;
    end else begin
      if (take) begin
        newest_q <= wr_addr;
        need_q   <= need_q - 1'b1;
      end
      if (fire) begin
        if (step) begin
          tap_q  <= '0;
          need_q <= NEED_W'(adv);
        end else begin
          tap_q  <= tap_q + 1'b1;
        end
      end
    end
  end

  rsp_phase_counter #(
    .NSUB(NSUB), .STRIDE(CNT_STRIDE), .START(START),
    .SUB_W(SUB_W), .ADV_W(ADV_W)
  ) i_cnt (
    .clk(clk), .rst_n(rst_n), .step(step & ~mode_q),
    .sub(c_sub), .adv(c_adv)
  );

  rsp_phase_table #(
    .NSUB(NSUB), .STRIDE(TBL_STRIDE), .START(START),
    .SUB_W(SUB_W), .ADV_W(ADV_W)
  ) i_tbl (
    .clk(clk), .rst_n(rst_n), .step(step & mode_q),
    .sub(t_sub), .adv(t_adv), .reuse(t_reuse)
  );

  assign sub = mode_q ? t_sub : c_sub;
  assign adv = mode_q ? t_adv : c_adv;

  rsp_sample_bank #(.DEPTH(DEPTH), .WIDTH(DATA_W)) i_bank (
    .clk(clk), .we(take), .waddr(wr_addr), .wdata(in_data),
    .raddr(out_addr), .rdata(out_data)
  );

  assign out_sub   = sub;
  assign out_addr  = newest_q - AW'(tap_q);
  assign out_coef  = CW'(tap_q) * CW'(NSUB) + CW'(sub);
  assign out_start = (tap_q == '0);
  assign out_last  = (int'(tap_q) == TAPS - 1);
  assign out_tgt   = mode_q & t_reuse;

  // samples loaded since reset, saturating at the tap count
  logic [NEED_W-1:0] fill_q;
  always_ff @(posedge clk) begin
    if (!rst_n) fill_q <= '0;
    else if (take && int'(fill_q) < TAPS) fill_q <= fill_q + 1'b1;
  end

  AST_NO_EARLY_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(fill_q) == TAPS); // R3

  AST_IN_OUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sub) &&
      $stable(out_coef) && $stable(out_addr) && $stable(out_data) &&
      $stable(out_start) && $stable(out_last) && $stable(out_tgt))); // R10

  AST_LAST_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last) |=> (!out_valid || out_start)); // R8

  AST_COEF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(out_coef) < NSUB * TAPS); // R7

  AST_MODE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_q)); // R11

endmodule

// File: tb/test_polyphase_sched.sv
module test_polyphase_sched;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        use_table = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [2:0]  out_sub;
  logic [3:0]  out_coef;
  logic [3:0]  out_addr;
  logic [31:0] out_data;
  logic        out_start, out_last, out_tgt;

  always #5 clk = ~clk;

  polyphase_sched i_polyphase_sched (
    .clk(clk), .rst_n(rst_n), .use_table(use_table),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sub(out_sub), .out_coef(out_coef), .out_addr(out_addr),
    .out_data(out_data), .out_start(out_start), .out_last(out_last),
    .out_tgt(out_tgt)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  int mdl_mode, mdl_cnt, mdl_need, mdl_ph, mdl_tap;
  logic [31:0] hist [16];
  bit first_beat;
  bit hold_pend;
  logic [55:0] hold_val;

  task automatic chk(input bit ok, input string tag, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int stride_of(input int m);
    return m ? 2 : 3;
  endfunction

  function automatic logic [55:0] pack_out();
    return {out_sub, out_coef, out_addr, out_data, out_start, out_last,
            out_tgt, 9'd0};
  endfunction

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 1'b0; use_table = m; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    mdl_mode = m; mdl_cnt = 0; mdl_need = 2; mdl_ph = 4; mdl_tap = 0;
    first_beat = 1; hold_pend = 0;
  endtask

  task automatic beat_check(input string otag);
    int s, newest, ea, ns;
    s = stride_of(mdl_mode);
    newest = mdl_cnt - 1;
    ea = (newest - mdl_tap) & 15;
    chk(out_sub == 3'(mdl_ph), otag, out_sub, mdl_ph);
    chk(out_addr == 4'(ea), "R6 read address", out_addr, ea);
    chk(out_data == hist[ea], "R6 read data", out_data, hist[ea]);
    chk(out_coef == 4'(mdl_tap * 5 + mdl_ph), "R7 coefficient address",
        out_coef, mdl_tap * 5 + mdl_ph);
    chk(out_start == (mdl_tap == 0), "R8 start marker", out_start,
        mdl_tap == 0);
    chk(out_last == (mdl_tap == 1), "R8 last marker", out_last,
        mdl_tap == 1);
    chk(out_tgt == (mdl_mode != 0 && (mdl_ph + s) / 5 == 0),
        "R9 target select", out_tgt, mdl_mode != 0 && (mdl_ph + s) / 5 == 0);
    if (first_beat) begin
      chk(out_addr == 4'd1, "R1 first bank words", out_addr, 1);
      first_beat = 0;
    end
    mdl_tap++;
    if (mdl_tap == 2) begin
      mdl_tap = 0;
      ns = (mdl_ph + s) / 5;
      mdl_ph = (mdl_ph + s) % 5;
      mdl_need = ns;
    end
  endtask

  task automatic run(input int n, input int pv, input int pr,
                     input bit toggle, input string otag);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      in_valid  = ($urandom_range(99) < pv);
      in_data   = $urandom();
      out_ready = ($urandom_range(99) < pr);
      if (toggle) use_table = 1'($urandom_range(1));
      #1;
      chk(in_ready == (mdl_need != 0), "R2 in_ready vs need", in_ready,
          mdl_need != 0);
      chk(out_valid == (mdl_need == 0), "R3 out_valid vs need", out_valid,
          mdl_need == 0);
      if (hold_pend) begin
        chk(out_valid == 1'b1, "R10 valid held", out_valid, 1);
        chk(pack_out() == hold_val, "R10 fields held", pack_out(), hold_val);
      end
      if (out_valid && out_ready) begin
        beat_check(otag);
      end else if (in_valid && in_ready) begin
        hist[mdl_cnt & 15] = in_data;
        mdl_cnt++;
        mdl_need--;
      end
      hold_pend = out_valid && !out_ready;
      hold_val  = pack_out();
    end
  endtask

  initial begin
    void'($urandom(32'd20240917));
    do_reset(0);
    run(3000, 60, 60, 0, "R4 counter order");
    do_reset(1);
    run(3000, 60, 60, 0, "R5 table order");
    do_reset(0);
    run(3000, 70, 25, 1, "R11 counter order with mode pin toggling");
    do_reset(1);
    run(3000, 100, 100, 1, "R11 table order with mode pin toggling");
    do_reset(0);
    run(2000, 100, 100, 0, "R4 counter order at full rate");
    do_reset(1);
    run(2000, 30, 90, 0, "R5 table order with sparse input");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule